// File: doc/BRIEF.md
# Condition Flag and Branch Decision Unit

This block sits beside the integer datapath of a small processor core. For each completed operation it takes the two source operands, the result the datapath produced, an operand size (byte or word) and an operation class. From these it derives the four condition flags: negative, zero, overflow and carry. Each operation class has its own rule for which flags it changes and how. The new flag set is offered combinationally every cycle. A write-enable strobe commits it into a flag register on the next rising clock edge.

The same block answers branch questions. A 4-bit condition code is evaluated against the committed flag register and gives a single taken/not-taken decision. Signed, unsigned and single-flag conditions are all covered. The register file, instruction fetch and branch target arithmetic are outside the block.

Top module: `flag_cond_unit`

## Requirements
- R1: For byte size (word_i=0) only bits 7:0 of the operands and result are used, and N is bit 7. For word size all 16 bits are used, and N is bit 15. Z is 1 exactly when the size-masked result is zero. Flag vectors are ordered bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R2: Class 0 (add): C is 1 when the unsigned sum of the masked operands exceeds the size mask. V is 1 when both operands share a sign bit and the result's sign differs from it.
- R3: Class 1 (subtract/compare): C is 1 when operand A is below operand B as unsigned masked values. V is 1 when the operand signs differ and the result's sign differs from operand A's sign.
- R4: Class 2 (logic): Z and N follow the result, V is cleared, and C keeps its registered value.
- R5: Class 3 (left shift) loads C from the top bit of operand A at the selected size. Class 4 (logical right shift) loads C from bit 0 of operand A. Both take Z and N from the result and clear V.
- R6: Class 5 (bit test): Z becomes the inverse of operand A's bit at bit_idx_i, with the index masked to 4 bits for word and 3 bits for byte. N, V and C keep their registered values.
- R7: Class 6 (multiply): Z and N come from the full 16-bit result whatever the size select, and V and C are cleared.
- R8: Condition codes 0 to 7 are: always, never, C=0 and Z=0, C=1 or Z=1, C=0, C=1, Z=0, Z=1.
- R9: Condition codes 8 to 15 are: V=0, V=1, N=0, N=1, N=V, N!=V, Z=0 and N=V, Z=1 or N!=V.
- R10: flags_o takes the value of flags_nxt_o at a rising edge where flag_we_i is 1, and is otherwise held. branch_taken_o is evaluated against flags_o, the committed flags.
- R11: A rising edge with rst_n low clears flags_o to 0000, and this overrides flag_we_i.
- R12: Class 7 is a no-op: flags_nxt_o equals flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a_i | input | 16 | Left operand (also the shifted / tested value) |
| op_b_i | input | 16 | Right operand |
| result_i | input | 16 | Datapath result of the operation |
| word_i | input | 1 | 1 = 16-bit size, 0 = 8-bit size |
| op_class_i | input | 3 | Operation class, encoding per R2 to R7 and R12 |
| bit_idx_i | input | 4 | Bit index for the bit test |
| cond_i | input | 4 | Branch condition code |
| flag_we_i | input | 1 | Commit flags_nxt_o at the next edge |
| flags_nxt_o | output | 4 | Combinational next flags {N,Z,V,C} |
| flags_o | output | 4 | Committed flag register {N,Z,V,C} |
| branch_taken_o | output | 1 | Condition decision against flags_o |

## Verification
A flag commit and a branch decision can fall in the same cycle. This happens when flag_we_i is high while a condition code that depends on the flag about to change is presented. The bench sets up exactly that case: zero is clear in the register while an equal-operand compare is pending with the write strobe high and "Z=1" selected. It expects the decision before the edge to follow the old flags (not taken) and the decision after the edge to follow the new ones (taken). Reset is also asserted together with a write strobe, to confirm that clearing takes precedence.

// File: rtl/flagu_pkg.sv
// Package: shared types for the condition flag unit.
// Assumes flag vectors are packed N,Z,V,C from MSB to LSB.
package flagu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        OPC_ADD   = 3'd0,
        OPC_SUB   = 3'd1,
        OPC_LOGIC = 3'd2,
        OPC_SHL   = 3'd3,
        OPC_SHR   = 3'd4,
        OPC_BTST  = 3'd5,
        OPC_MUL   = 3'd6,
        OPC_NONE  = 3'd7
    } op_class_e;

endpackage

// File: rtl/flagu_arith.sv
// Module: carry and overflow for add and subtract at byte or word size.
// Assumes byte size is half of DATA_W and that result_i is the datapath's sum/difference.
module flagu_arith #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              word_i,
    input  logic              sub_i,
    output logic              c_o,
    output logic              v_o
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    logic [DATA_W:0]   sum;
    logic              sa;
    logic              sb;
    logic              sr;

    // Mask operands to size, pick sign bits, then derive carry/borrow and overflow.
    always_comb begin
        a_m = word_i ? a_i : {{BYTE_W{1'b0}}, a_i[BYTE_W-1:0]};
        b_m = word_i ? b_i : {{BYTE_W{1'b0}}, b_i[BYTE_W-1:0]};
        sum = {1'b0, a_m} + {1'b0, b_m};
        sa  = word_i ? a_i[DATA_W-1]   : a_i[BYTE_W-1];
        sb  = word_i ? b_i[DATA_W-1]   : b_i[BYTE_W-1];
        sr  = word_i ? res_i[DATA_W-1] : res_i[BYTE_W-1];
        if (sub_i) begin
            c_o = (a_m < b_m);
            v_o = (sa != sb) && (sr != sa);
        end else begin
            c_o = word_i ? sum[DATA_W] : sum[BYTE_W];
            v_o = (sa == sb) && (sr != sa);
        end
    end
endmodule

// File: rtl/flagu_bit_test.sv
// Module: selects one bit of a value with a size-dependent index mask.
// Assumes DATA_W is a power of two; byte size is DATA_W/2.
module flagu_bit_test #(
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              word_i,
    output logic              bit_o
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int BIDX_W = $clog2(BYTE_W);

    logic [IDX_W-1:0] eff_idx;

    // Trim the index to the size's range and pick the addressed bit.
    always_comb begin
        eff_idx = word_i ? idx_i : {{(IDX_W-BIDX_W){1'b0}}, idx_i[BIDX_W-1:0]};
        bit_o   = value_i[eff_idx];
    end
endmodule

// File: rtl/flagu_cond_eval.sv
// Module: evaluates a 4-bit branch condition against a flag set.
// Assumes odd codes are the complement of the even code below them.
module flagu_cond_eval
    import flagu_pkg::*;
(
    input  flags_t      flags_i,
    input  logic [3:0]  cond_i,
    output logic        taken_o
);
    logic base;

    // Evaluate the positive-sense test of the code pair, then apply the sense bit.
    always_comb begin
        case (cond_i[3:1])
            3'd0:    base = 1'b1;
            3'd1:    base = !flags_i.c && !flags_i.z;
            3'd2:    base = !flags_i.c;
            3'd3:    base = !flags_i.z;
            3'd4:    base = !flags_i.v;
            3'd5:    base = !flags_i.n;
            3'd6:    base = (flags_i.n == flags_i.v);
            default: base = !flags_i.z && (flags_i.n == flags_i.v);
        endcase
        taken_o = base ^ cond_i[0];
    end
endmodule

// File: rtl/flag_cond_unit.sv
// Module: condition flag generation, flag register and branch decision.
// Assumes result_i is already computed by the datapath; the block only derives flags.
module flag_cond_unit
    import flagu_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              word_i,
    input  logic [2:0]        op_class_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [3:0]        cond_i,
    input  logic              flag_we_i,
    output logic [3:0]        flags_nxt_o,
    output logic [3:0]        flags_o,
    output logic              branch_taken_o
);
    localparam int BYTE_W = DATA_W / 2;

    flags_t flags_q;
    flags_t flags_nxt;
    logic   ar_c;
    logic   ar_v;
    logic   tbit;
    logic   z_sz;
    logic   n_sz;
    logic   top_a;

    flagu_arith #(.DATA_W(DATA_W)) arith_i (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .res_i  (result_i),
        .word_i (word_i),
        .sub_i  (op_class_i == OPC_SUB),
        .c_o    (ar_c),
        .v_o    (ar_v)
    );

    flagu_bit_test #(.DATA_W(DATA_W)) btst_i (
        .value_i (op_a_i),
        .idx_i   (bit_idx_i),
        .word_i  (word_i),
        .bit_o   (tbit)
    );

    flagu_cond_eval cond_i_u (
        .flags_i (flags_q),
        .cond_i  (cond_i),
        .taken_o (branch_taken_o)
    );

    // Size-masked zero/negative of the result and top bit of operand A.
    always_comb begin
        z_sz  = word_i ? (result_i == '0) : (result_i[BYTE_W-1:0] == '0);
        n_sz  = word_i ? result_i[DATA_W-1] : result_i[BYTE_W-1];
        top_a = word_i ? op_a_i[DATA_W-1]   : op_a_i[BYTE_W-1];
    end

    // Select the flag rule for the operation class; unchanged flags keep the register value.
    always_comb begin
        flags_nxt = flags_q;
        case (op_class_i)
            OPC_ADD, OPC_SUB: begin
                flags_nxt.n = n_sz;
                flags_nxt.z = z_sz;
                flags_nxt.v = ar_v;
                flags_nxt.c = ar_c;
            end
            OPC_LOGIC: begin
                flags_nxt.n = n_sz;
                flags_nxt.z = z_sz;
                flags_nxt.v = 1'b0;
            end
            OPC_SHL: begin
                flags_nxt.n = n_sz;
                flags_nxt.z = z_sz;
                flags_nxt.v = 1'b0;
                flags_nxt.c = top_a;
            end
            OPC_SHR: begin
                flags_nxt.n = n_sz;
                flags_nxt.z = z_sz;
                flags_nxt.v = 1'b0;
                flags_nxt.c = op_a_i[0];
            end
            OPC_BTST: begin
                flags_nxt.z = !tbit;
            end
            OPC_MUL: begin
                flags_nxt.n = result_i[DATA_W-1];
                flags_nxt.z = (result_i == '0);
                flags_nxt.v = 1'b0;
                flags_nxt.c = 1'b0;
            end
            default: begin
                flags_nxt = flags_q;
            end
        endcase
    end

    // Flag register: synchronous clear, commit on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (flag_we_i) begin
            flags_q <= flags_nxt;
        end
    end

    assign flags_nxt_o = flags_nxt;
    assign flags_o     = flags_q;
endmodule

// File: rtl/flag_cond_unit_chk.sv
// Module: property checker for flag_cond_unit, attached by bind.
// Assumes the N,Z,V,C packing of the flag vectors.
module flag_cond_unit_chk
    import flagu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_class_i,
    input logic [3:0] cond_i,
    input logic       flag_we_i,
    input logic [3:0] flags_nxt_o,
    input logic [3:0] flags_o,
    input logic       branch_taken_o
);
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> flags_o == 4'b0000);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o));

    assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flags_o == $past(flags_nxt_o));

    assert_logic_keeps_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_i == OPC_LOGIC |-> (!flags_nxt_o[1] && flags_nxt_o[0] == flags_o[0]));

    assert_btst_keeps_nvc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_i == OPC_BTST |-> (flags_nxt_o[3] == flags_o[3] && flags_nxt_o[1:0] == flags_o[1:0]));

    assert_mul_clears_vc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_i == OPC_MUL |-> flags_nxt_o[1:0] == 2'b00);

    assert_always_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == 4'd0 |-> branch_taken_o);

    assert_never_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i == 4'd1 |-> !branch_taken_o);

    assert_noop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_i == OPC_NONE |-> flags_nxt_o == flags_o);
endmodule

bind flag_cond_unit flag_cond_unit_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_class_i     (op_class_i),
    .cond_i         (cond_i),
    .flag_we_i      (flag_we_i),
    .flags_nxt_o    (flags_nxt_o),
    .flags_o        (flags_o),
    .branch_taken_o (branch_taken_o)
);

// File: tb/flag_cond_unit_tb.sv
// Directed bench for flag_cond_unit: one task per scenario, each checking its own results.
module flag_cond_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_a, op_b, res;
    logic        word;
    logic [2:0]  cls;
    logic [3:0]  bidx;
    logic [3:0]  cond;
    logic        we;
    logic [3:0]  flags_nxt, flags;
    logic        taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flag_cond_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_a_i         (op_a),
        .op_b_i         (op_b),
        .result_i       (res),
        .word_i         (word),
        .op_class_i     (cls),
        .bit_idx_i      (bidx),
        .cond_i         (cond),
        .flag_we_i      (we),
        .flags_nxt_o    (flags_nxt),
        .flags_o        (flags),
        .branch_taken_o (taken)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Branch decision per R8/R9; flags packed {N,Z,V,C}.
    function automatic logic cond_ref(input logic [3:0] f, input logic [3:0] c);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return !cy && !z;
            4'h3: return cy || z;
            4'h4: return !cy;
            4'h5: return cy;
            4'h6: return !z;
            4'h7: return z;
            4'h8: return !v;
            4'h9: return v;
            4'hA: return !n;
            4'hB: return n;
            4'hC: return n == v;
            4'hD: return n != v;
            4'hE: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    // Drive one operation, check the combinational flags, commit, check the register.
    task automatic apply(input string tag, input logic [2:0] c, input logic w,
                         input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                         input logic [3:0] idx, input logic [3:0] exp);
        @(negedge clk);
        cls = c; word = w; op_a = a; op_b = b; res = r; bidx = idx; we = 1'b1;
        #1;
        check({tag, " next"}, flags_nxt, exp);
        @(posedge clk);
        #1;
        we = 1'b0;
        check({tag, " reg"}, flags, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; we = 1'b0; cls = 3'd7; word = 1'b0;
        op_a = '0; op_b = '0; res = '0; bidx = '0; cond = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset value", flags, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        apply("R2 byte signed overflow", 3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        apply("R2 byte carry zero",      3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 4'd0, 4'b0101);
        apply("R2 word carry zero",      3'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 4'd0, 4'b0101);
        apply("R2 word signed overflow", 3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 4'd0, 4'b1010);
        apply("R1 byte ignores upper",   3'd0, 1'b0, 16'h12F0, 16'h3420, 16'h4710, 4'd0, 4'b0001);
    endtask

    task automatic t_sub();
        apply("R3 byte borrow",          3'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 4'd0, 4'b1001);
        apply("R3 byte overflow",        3'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 4'd0, 4'b0010);
        apply("R3 word equal",           3'd1, 1'b1, 16'h1234, 16'h1234, 16'h0000, 4'd0, 4'b0100);
        apply("R3 word overflow",        3'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 4'd0, 4'b0010);
        apply("R1 byte compare masked",  3'd1, 1'b0, 16'hAB05, 16'h0105, 16'hAA00, 4'd0, 4'b0100);
    endtask

    task automatic t_logic();
        apply("R4 setup C=1",            3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 4'd0, 4'b0101);
        apply("R4 word neg keeps C",     3'd2, 1'b1, 16'h0000, 16'h0000, 16'h8000, 4'd0, 4'b1001);
        apply("R4 byte zero keeps C",    3'd2, 1'b0, 16'h0000, 16'h0000, 16'hFF00, 4'd0, 4'b0101);
        apply("R4 setup V=1 C=0",        3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        apply("R4 clears V",             3'd2, 1'b1, 16'h0000, 16'h0000, 16'h0001, 4'd0, 4'b0000);
    endtask

    task automatic t_shift();
        apply("R5 shl byte top to C",    3'd3, 1'b0, 16'h0081, 16'h0000, 16'h0102, 4'd0, 4'b0001);
        apply("R5 shl word",             3'd3, 1'b1, 16'h4000, 16'h0000, 16'h8000, 4'd0, 4'b1000);
        apply("R5 shl byte zero",        3'd3, 1'b0, 16'h0080, 16'h0000, 16'h0100, 4'd0, 4'b0101);
        apply("R5 shr word bit0",        3'd4, 1'b1, 16'h0001, 16'h0000, 16'h0000, 4'd0, 4'b0101);
        apply("R5 shr byte no carry",    3'd4, 1'b0, 16'hFF02, 16'h0000, 16'h0001, 4'd0, 4'b0000);
        apply("R5 shr byte carry",       3'd4, 1'b0, 16'h0083, 16'h0000, 16'h0041, 4'd0, 4'b0001);
    endtask

    task automatic t_btst();
        apply("R6 setup N=1 V=1",        3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        apply("R6 word bit15 set",       3'd5, 1'b1, 16'h8000, 16'h0000, 16'h0000, 4'hF, 4'b1010);
        apply("R6 word bit14 clear",     3'd5, 1'b1, 16'h8000, 16'h0000, 16'h0000, 4'hE, 4'b1110);
        apply("R6 byte index masked set",   3'd5, 1'b0, 16'h0001, 16'h0000, 16'h0000, 4'h8, 4'b1010);
        apply("R6 byte index masked clear", 3'd5, 1'b0, 16'h0100, 16'h0000, 16'h0000, 4'h8, 4'b1110);
    endtask

    task automatic t_mul();
        apply("R7 setup C=1",            3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 4'd0, 4'b0101);
        apply("R7 negative clears C",    3'd6, 1'b0, 16'h0080, 16'h0100, 16'h8000, 4'd0, 4'b1000);
        apply("R7 word rule at byte size", 3'd6, 1'b0, 16'h0010, 16'h0010, 16'h0100, 4'd0, 4'b0000);
    endtask

    task automatic t_noop();
        apply("R12 setup",               3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        apply("R12 class 7 holds",       3'd7, 1'b1, 16'hFFFF, 16'h1234, 16'h0000, 4'd3, 4'b1010);
    endtask

    // Walk all sixteen codes against the committed flags.
    task automatic sweep_cond(input logic [3:0] f);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cond = 4'(k);
            #1;
            check($sformatf("%s cond %0d flags %b", (k < 8) ? "R8" : "R9", k, f),
                  {3'b000, taken}, {3'b000, cond_ref(f, 4'(k))});
        end
    endtask

    task automatic t_cond();
        apply("R9 load", 3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        sweep_cond(4'b1010);
        apply("R8 load", 3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0100, 4'd0, 4'b0101);
        sweep_cond(4'b0101);
        apply("R9 load", 3'd1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 4'd0, 4'b1001);
        sweep_cond(4'b1001);
        apply("R9 load", 3'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 4'd0, 4'b0010);
        sweep_cond(4'b0010);
        apply("R8 load", 3'd2, 1'b1, 16'h0000, 16'h0000, 16'h0001, 4'd0, 4'b0000);
        sweep_cond(4'b0000);
        apply("R8 load", 3'd1, 1'b1, 16'h1234, 16'h1234, 16'h0000, 4'd0, 4'b0100);
        sweep_cond(4'b0100);
    endtask

    // Commit and branch in the same cycle: decision follows the old flags until the edge.
    task automatic t_same_cycle();
        apply("R10 setup Z=0", 3'd2, 1'b1, 16'h0000, 16'h0000, 16'h0001, 4'd0, 4'b0000);
        @(negedge clk);
        cls = 3'd1; word = 1'b1; op_a = 16'h5555; op_b = 16'h5555; res = 16'h0000;
        cond = 4'h7; we = 1'b1;
        #1;
        check("R10 decision before commit", {3'b000, taken}, 4'b0000);
        @(posedge clk);
        #1;
        we = 1'b0;
        check("R10 decision after commit", {3'b000, taken}, 4'b0001);
        check("R10 register after commit", flags, 4'b0100);
        @(negedge clk);
        cls = 3'd0; word = 1'b0; op_a = 16'h007F; op_b = 16'h0001; res = 16'h0080;
        @(posedge clk);
        #1;
        check("R10 held without strobe", flags, 4'b0100);
    endtask

    // Reset together with a write strobe clears the register.
    task automatic t_reset_wins();
        apply("R11 setup nonzero", 3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 4'd0, 4'b1010);
        @(negedge clk);
        rst_n = 1'b0; we = 1'b1;
        cls = 3'd0; word = 1'b0; op_a = 16'h00FF; op_b = 16'h0001; res = 16'h0100;
        @(posedge clk);
        #1;
        check("R11 reset beats strobe", flags, 4'b0000);
        @(negedge clk);
        we = 1'b0; rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_btst();
        t_mul();
        t_noop();
        t_cond();
        t_same_cycle();
        t_reset_wins();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule